// File: doc/BRIEF.md
# Load/Store Address and Byte-Lane Unit

This block sits between the register file and the data memory bus of a 32-bit load/store pipeline. It forms the effective byte address of a word, halfword or byte access from a base register value and an offset. The offset is either a short unsigned immediate or a second register value, and it may be added to or subtracted from the base. It also produces the updated base value for the indexing modes that modify the base register. Pre-indexed accesses use base plus or minus offset as the address and return that sum to the base only when the writeback flag is set. Post-indexed accesses put the untouched base on the bus and always return the sum to the base register.

On the data side the block turns a register value into bus store data and byte-lane enables. It also extracts a zero-extended byte or halfword from the 32-bit read bus for loads. Lane placement follows the byte order chosen for the chip, little-endian or big-endian. That choice is captured while reset is asserted and is then held for the rest of operation. A misaligned or reserved-size request raises an error flag and suppresses every side effect. The datapath is combinational; the only state is the captured byte-order mode.

Top module: `ls_lane_unit`

## Requirements
- R1: With pre_index=1 and writeback=0, mem_addr equals base_val plus the offset, and base_wb_en stays 0.
- R2: With pre_index=1 and writeback=1, mem_addr and base_wb_val both equal base_val plus the offset, and base_wb_en is 1.
- R3: With pre_index=0, mem_addr equals base_val and base_wb_en is 1 whatever writeback holds. base_wb_val equals base_val combined with the offset.
- R4: use_imm=1 selects imm_offset, zero-extended to 32 bits, as the offset; use_imm=0 selects reg_offset. offset_sub=1 subtracts the offset modulo 2^32 instead of adding it.
- R5: Let o=mem_addr[1:0] and lane(o) = o in little-endian mode or 3-o in big-endian mode, where lane k is bits 8k+7..8k. A byte access (req_size=00) enables lane(o). A halfword access (req_size=01) enables lane(o) and lane(o+1). A word access (req_size=10) enables all four lanes.
- R6: mem_wdata is store_val[7:0] copied into all four lanes for a byte access, store_val[15:0] copied into both halves for a halfword, and store_val for a word. mem_wr is 1 only for a valid, aligned store (req_store=1).
- R7: load_data is the byte in lane(o) zero-extended for a byte access. For a halfword access it is the zero-extended halfword whose low-order byte is at address o+1 in big-endian mode or at o in little-endian mode. For a word access it is mem_rdata.
- R8: A halfword with mem_addr[0]=1, a word with mem_addr[1:0]!=0, or req_size=11 raises align_err when req_valid=1. In that case mem_lane_en is 0, mem_wr is 0, base_wb_en is 0 and load_data is 0.
- R9: The byte order is taken from cfg_big_endian (1 = big-endian) while rst=1. A change of cfg_big_endian after reset has no effect on lane placement.
- R10: With req_valid=0, mem_lane_en, mem_wr, base_wb_en and align_err are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the byte-order mode register |
| rst | input | 1 | Synchronous reset, active high; byte order is captured while high |
| cfg_big_endian | input | 1 | Byte-order selection, 1 = big-endian, sampled during reset |
| req_valid | input | 1 | An access is presented this cycle |
| req_store | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | 00 byte, 01 halfword, 10 word, 11 reserved |
| base_val | input | 32 | Base register value |
| reg_offset | input | 32 | Register offset value |
| imm_offset | input | 12 | Unsigned immediate offset |
| use_imm | input | 1 | 1 = immediate offset, 0 = register offset |
| offset_sub | input | 1 | 1 = subtract the offset, 0 = add it |
| pre_index | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| writeback | input | 1 | Base update request for pre-indexed accesses |
| store_val | input | 32 | Register value to store |
| mem_rdata | input | 32 | Read data from the memory bus |
| mem_addr | output | 32 | Byte address of the access |
| mem_lane_en | output | 4 | Byte-lane enables |
| mem_wr | output | 1 | Write strobe to memory |
| mem_wdata | output | 32 | Lane-replicated store data |
| load_data | output | 32 | Zero-extended load result |
| align_err | output | 1 | Misaligned or reserved-size request |
| base_wb_val | output | 32 | Updated base value |
| base_wb_en | output | 1 | Base register write enable |

## Verification
The checker assumes that a request and all of its operand inputs are stable around each rising clock edge. It also assumes that nothing is requested while reset is high, because the byte order is being captured then. The bench keeps to this by changing inputs only just after a falling edge and sampling one nanosecond later, long before the next rising edge. It holds req_valid low throughout reset. Byte-order changes are only made through a fresh reset, except in the one scenario that deliberately toggles cfg_big_endian outside reset to show that the toggle is ignored.

// File: rtl/ls_lane_pkg.sv
package ls_lane_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_RSVD = 2'b11
  } acc_size_e;

endpackage

// File: rtl/ls_addr_gen.sv
module ls_addr_gen #(
  parameter int ADDR_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] reg_offset,
  input  logic [IMM_W-1:0]  imm_offset,
  input  logic              use_imm,
  input  logic              offset_sub,
  input  logic              pre_index,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [ADDR_W-1:0] upd_base
);

  localparam int PAD_W = ADDR_W - IMM_W;

  function automatic logic [ADDR_W-1:0] apply_offset(
    input logic [ADDR_W-1:0] b,
    input logic [ADDR_W-1:0] o,
    input logic              neg
  );
    return neg ? (b - o) : (b + o);
  endfunction

  logic [ADDR_W-1:0] offset_sel;
  logic [ADDR_W-1:0] combined;

  always_comb begin
    offset_sel = use_imm ? {{PAD_W{1'b0}}, imm_offset} : reg_offset;
    combined   = apply_offset(base_val, offset_sel, offset_sub);
    eff_addr   = pre_index ? combined : base_val;
    upd_base   = combined;
  end

endmodule

// File: rtl/ls_lane_sel.sv
module ls_lane_sel
  import ls_lane_pkg::*;
#(
  parameter int LANES     = 4,
  parameter int LANE_BITS = $clog2(LANES)
) (
  input  logic                 big_mode,
  input  logic [1:0]           size,
  input  logic [LANE_BITS-1:0] addr_lo,
  output logic [LANES-1:0]     lane_raw,
  output logic [LANE_BITS-1:0] low_lane,
  output logic                 misalign
);

  localparam logic [LANE_BITS-1:0] TOP_LANE  = LANE_BITS'(LANES - 1);
  localparam logic [LANE_BITS-1:0] HALF_BASE = LANE_BITS'(LANES - 2);

  logic [LANE_BITS-1:0] half_off;
  logic [LANE_BITS-1:0] byte_lane;
  logic [LANE_BITS-1:0] half_lane;

  always_comb begin
    half_off  = {addr_lo[LANE_BITS-1:1], 1'b0};
    byte_lane = big_mode ? (TOP_LANE - addr_lo) : addr_lo;
    half_lane = big_mode ? (HALF_BASE - half_off) : half_off;
    lane_raw  = '0;
    low_lane  = '0;
    misalign  = 1'b0;
    case (acc_size_e'(size))
      SZ_BYTE: begin
        lane_raw = LANES'(1) << byte_lane;
        low_lane = byte_lane;
      end
      SZ_HALF: begin
        lane_raw = LANES'(3) << half_lane;
        low_lane = half_lane;
        misalign = addr_lo[0];
      end
      SZ_WORD: begin
        lane_raw = '1;
        misalign = (addr_lo != '0);
      end
      default: misalign = 1'b1;
    endcase
  end

endmodule

// File: rtl/ls_store_fmt.sv
module ls_store_fmt
  import ls_lane_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        size,
  input  logic [DATA_W-1:0] store_val,
  output logic [DATA_W-1:0] wdata
);

  localparam int LANES = DATA_W / 8;
  localparam int HALVES = DATA_W / 16;

  logic [DATA_W-1:0] byte_rep;
  logic [DATA_W-1:0] half_rep;

  for (genvar i = 0; i < LANES; i++) begin : g_byte_rep
    assign byte_rep[i*8 +: 8] = store_val[7:0];
  end

  for (genvar j = 0; j < HALVES; j++) begin : g_half_rep
    assign half_rep[j*16 +: 16] = store_val[15:0];
  end

  always_comb begin
    case (acc_size_e'(size))
      SZ_BYTE: wdata = byte_rep;
      SZ_HALF: wdata = half_rep;
      default: wdata = store_val;
    endcase
  end

endmodule

// File: rtl/ls_load_fmt.sv
module ls_load_fmt
  import ls_lane_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int LANE_BITS = $clog2(DATA_W / 8)
) (
  input  logic [1:0]           size,
  input  logic [LANE_BITS-1:0] low_lane,
  input  logic                 misalign,
  input  logic [DATA_W-1:0]    rdata,
  output logic [DATA_W-1:0]    load_data
);

  logic [DATA_W-1:0] shifted;

  always_comb begin
    shifted = rdata >> {low_lane, 3'b000};
    if (misalign) begin
      load_data = '0;
    end else begin
      case (acc_size_e'(size))
        SZ_BYTE: load_data = DATA_W'(shifted[7:0]);
        SZ_HALF: load_data = DATA_W'(shifted[15:0]);
        default: load_data = rdata;
      endcase
    end
  end

endmodule

// File: rtl/ls_lane_unit.sv
module ls_lane_unit #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int IMM_W  = 12
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cfg_big_endian,
  input  logic                  req_valid,
  input  logic                  req_store,
  input  logic [1:0]            req_size,
  input  logic [ADDR_W-1:0]     base_val,
  input  logic [ADDR_W-1:0]     reg_offset,
  input  logic [IMM_W-1:0]      imm_offset,
  input  logic                  use_imm,
  input  logic                  offset_sub,
  input  logic                  pre_index,
  input  logic                  writeback,
  input  logic [DATA_W-1:0]     store_val,
  input  logic [DATA_W-1:0]     mem_rdata,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W/8-1:0]   mem_lane_en,
  output logic                  mem_wr,
  output logic [DATA_W-1:0]     mem_wdata,
  output logic [DATA_W-1:0]     load_data,
  output logic                  align_err,
  output logic [ADDR_W-1:0]     base_wb_val,
  output logic                  base_wb_en
);

  localparam int LANES     = DATA_W / 8;
  localparam int LANE_BITS = $clog2(LANES);

  logic                 big_mode_q;
  logic [LANES-1:0]     lane_raw;
  logic [LANE_BITS-1:0] low_lane;
  logic                 misalign;
  logic                 access_ok;
  logic                 base_update;

  always_ff @(posedge clk) begin
    if (rst) begin
      big_mode_q <= cfg_big_endian;
    end
  end

  ls_addr_gen #(
    .ADDR_W (ADDR_W),
    .IMM_W  (IMM_W)
  ) u_addr (
    .base_val   (base_val),
    .reg_offset (reg_offset),
    .imm_offset (imm_offset),
    .use_imm    (use_imm),
    .offset_sub (offset_sub),
    .pre_index  (pre_index),
    .eff_addr   (mem_addr),
    .upd_base   (base_wb_val)
  );

  ls_lane_sel #(
    .LANES     (LANES),
    .LANE_BITS (LANE_BITS)
  ) u_lanes (
    .big_mode (big_mode_q),
    .size     (req_size),
    .addr_lo  (mem_addr[LANE_BITS-1:0]),
    .lane_raw (lane_raw),
    .low_lane (low_lane),
    .misalign (misalign)
  );

  ls_store_fmt #(
    .DATA_W (DATA_W)
  ) u_store (
    .size      (req_size),
    .store_val (store_val),
    .wdata     (mem_wdata)
  );

  ls_load_fmt #(
    .DATA_W    (DATA_W),
    .LANE_BITS (LANE_BITS)
  ) u_load (
    .size      (req_size),
    .low_lane  (low_lane),
    .misalign  (misalign),
    .rdata     (mem_rdata),
    .load_data (load_data)
  );

  always_comb begin
    access_ok   = req_valid && !misalign;
    base_update = !pre_index || writeback;
    mem_lane_en = access_ok ? lane_raw : '0;
    mem_wr      = access_ok && req_store;
    align_err   = req_valid && misalign;
    base_wb_en  = access_ok && base_update;
  end

endmodule

// File: rtl/ls_lane_unit_chk.sv
module ls_lane_unit_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_store,
  input logic [1:0]  req_size,
  input logic        pre_index,
  input logic [31:0] base_val,
  input logic [31:0] mem_addr,
  input logic [3:0]  mem_lane_en,
  input logic        mem_wr,
  input logic        align_err,
  input logic        base_wb_en,
  input logic        big_mode_q
);

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |-> (mem_lane_en == 4'b0000) && !mem_wr && !base_wb_en && !align_err);

  assert_err_no_effect_R8: assert property (@(posedge clk) disable iff (rst)
    align_err |-> (mem_lane_en == 4'b0000) && !mem_wr && !base_wb_en);

  assert_post_addr_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !pre_index) |-> (mem_addr == base_val));

  assert_post_forces_wb_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !pre_index && !align_err) |-> base_wb_en);

  assert_lane_count_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !align_err) |->
      ($countones(mem_lane_en) == ((req_size == 2'b00) ? 1 : (req_size == 2'b01) ? 2 : 4)));

  assert_first_byte_lane_R5: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !align_err && req_size == 2'b00 && mem_addr[1:0] == 2'b00) |->
      (big_mode_q ? mem_lane_en[3] : mem_lane_en[0]));

  assert_write_is_store_R6: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (req_store && req_valid));

  assert_mode_held_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> $stable(big_mode_q));

endmodule

bind ls_lane_unit ls_lane_unit_chk u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_store   (req_store),
  .req_size    (req_size),
  .pre_index   (pre_index),
  .base_val    (base_val),
  .mem_addr    (mem_addr),
  .mem_lane_en (mem_lane_en),
  .mem_wr      (mem_wr),
  .align_err   (align_err),
  .base_wb_en  (base_wb_en),
  .big_mode_q  (big_mode_q)
);

// File: tb/ls_lane_unit_test.sv
`timescale 1ns/1ps
module ls_lane_unit_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_big_endian = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_store = 1'b0;
  logic [1:0]  req_size = 2'b10;
  logic [31:0] base_val = '0;
  logic [31:0] reg_offset = '0;
  logic [11:0] imm_offset = '0;
  logic        use_imm = 1'b0;
  logic        offset_sub = 1'b0;
  logic        pre_index = 1'b1;
  logic        writeback = 1'b0;
  logic [31:0] store_val = '0;
  logic [31:0] mem_rdata = '0;
  logic [31:0] mem_addr;
  logic [3:0]  mem_lane_en;
  logic        mem_wr;
  logic [31:0] mem_wdata;
  logic [31:0] load_data;
  logic        align_err;
  logic [31:0] base_wb_val;
  logic        base_wb_en;

  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ls_lane_unit uut (
    .clk(clk), .rst(rst), .cfg_big_endian(cfg_big_endian),
    .req_valid(req_valid), .req_store(req_store), .req_size(req_size),
    .base_val(base_val), .reg_offset(reg_offset), .imm_offset(imm_offset),
    .use_imm(use_imm), .offset_sub(offset_sub), .pre_index(pre_index),
    .writeback(writeback), .store_val(store_val), .mem_rdata(mem_rdata),
    .mem_addr(mem_addr), .mem_lane_en(mem_lane_en), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .load_data(load_data), .align_err(align_err),
    .base_wb_val(base_wb_val), .base_wb_en(base_wb_en)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // bus lane holding the byte at address offset o
  function automatic int lane_of(input bit big, input int o);
    return big ? (3 - o) : o;
  endfunction

  function automatic logic [7:0] byte_at(input bit big, input logic [31:0] rd, input int o);
    return rd[8*lane_of(big, o) +: 8];
  endfunction

  function automatic logic [3:0] exp_lanes(input bit big, input int sz, input int o);
    logic [3:0] e = '0;
    if (sz == 0) e[lane_of(big, o)] = 1'b1;
    else if (sz == 1) begin
      e[lane_of(big, o)] = 1'b1;
      e[lane_of(big, o + 1)] = 1'b1;
    end else e = 4'hF;
    return e;
  endfunction

  function automatic logic [31:0] exp_load(input bit big, input int sz, input int o,
                                           input logic [31:0] rd);
    if (sz == 0) return {24'h0, byte_at(big, rd, o)};
    if (sz == 1) return big ? {16'h0, byte_at(big, rd, o), byte_at(big, rd, o + 1)}
                            : {16'h0, byte_at(big, rd, o + 1), byte_at(big, rd, o)};
    return big ? {byte_at(big, rd, 0), byte_at(big, rd, 1), byte_at(big, rd, 2), byte_at(big, rd, 3)}
               : {byte_at(big, rd, 3), byte_at(big, rd, 2), byte_at(big, rd, 1), byte_at(big, rd, 0)};
  endfunction

  task automatic settle();
    #1;
  endtask

  task automatic do_reset(input bit big);
    @(negedge clk);
    req_valid = 1'b0;
    rst = 1'b1;
    cfg_big_endian = big;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic set_req(input bit st, input logic [1:0] sz, input logic [31:0] base,
                         input logic [31:0] roff, input logic [11:0] imm, input bit ui,
                         input bit sub, input bit pre, input bit wb);
    @(negedge clk);
    req_valid = 1'b1; req_store = st; req_size = sz; base_val = base;
    reg_offset = roff; imm_offset = imm; use_imm = ui; offset_sub = sub;
    pre_index = pre; writeback = wb;
    settle();
  endtask

  task automatic t_idle();
    @(negedge clk);
    req_valid = 1'b0; req_store = 1'b1; req_size = 2'b10; base_val = 32'h0000_1003;
    pre_index = 1'b0; writeback = 1'b1;
    settle();
    chk("R10 idle lanes", {28'h0, mem_lane_en}, 32'h0);
    chk("R10 idle wr", {31'h0, mem_wr}, 32'h0);
    chk("R10 idle wb_en", {31'h0, base_wb_en}, 32'h0);
    chk("R10 idle err", {31'h0, align_err}, 32'h0);
  endtask

  task automatic t_pre_plain();
    set_req(1'b0, 2'b10, 32'h0000_2000, 32'h0000_0040, 12'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R1 pre addr", mem_addr, 32'h0000_2040);
    chk("R1 pre no wb", {31'h0, base_wb_en}, 32'h0);
  endtask

  task automatic t_pre_wb();
    set_req(1'b0, 2'b10, 32'h1000_0000, 32'h0, 12'h010, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R2 pre wb addr", mem_addr, 32'h1000_0010);
    chk("R2 pre wb val", base_wb_val, 32'h1000_0010);
    chk("R2 pre wb en", {31'h0, base_wb_en}, 32'h1);
  endtask

  task automatic t_post();
    for (int wb = 0; wb < 2; wb++) begin
      set_req(1'b1, 2'b10, 32'h0000_3000, 32'h0, 12'h010, 1'b1, 1'b0, 1'b0, wb[0]);
      chk("R3 post addr", mem_addr, 32'h0000_3000);
      chk("R3 post wb val", base_wb_val, 32'h0000_3010);
      chk("R3 post wb en", {31'h0, base_wb_en}, 32'h1);
    end
  endtask

  task automatic t_sub();
    set_req(1'b0, 2'b10, 32'h0000_0100, 32'h0000_0104, 12'h0, 1'b0, 1'b1, 1'b1, 1'b1);
    chk("R4 reg sub wrap", mem_addr, 32'hFFFF_FFFC);
    set_req(1'b0, 2'b10, 32'h0000_8000, 32'hDEAD_0000, 12'hFFC, 1'b1, 1'b1, 1'b1, 1'b1);
    chk("R4 imm sub zero-ext", mem_addr, 32'h0000_7004);
    set_req(1'b0, 2'b10, 32'h0000_8000, 32'hDEAD_0000, 12'hFFC, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R4 imm add zero-ext", mem_addr, 32'h0000_8FFC);
    set_req(1'b0, 2'b10, 32'h0000_8000, 32'h0000_0020, 12'h004, 1'b0, 1'b0, 1'b1, 1'b1);
    chk("R4 reg add selected", mem_addr, 32'h0000_8020);
  endtask

  task automatic t_lanes_loads(input bit big);
    mem_rdata = 32'hA1B2_C3D4;
    for (int sz = 0; sz < 3; sz++) begin
      for (int o = 0; o < 4; o += (sz == 0) ? 1 : (sz == 1) ? 2 : 4) begin
        set_req(1'b0, sz[1:0], 32'h0000_4000 + o, 32'h0, 12'h0, 1'b1, 1'b0, 1'b1, 1'b0);
        chk(big ? "R5 lanes big" : "R5 lanes little", {28'h0, mem_lane_en},
            {28'h0, exp_lanes(big, sz, o)});
        chk(big ? "R7 load big" : "R7 load little", load_data, exp_load(big, sz, o, mem_rdata));
        chk("R5 no err", {31'h0, align_err}, 32'h0);
      end
    end
  endtask

  task automatic t_store();
    @(negedge clk); store_val = 32'h1234_5678;
    set_req(1'b1, 2'b00, 32'h0000_5001, 32'h0, 12'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R6 byte wdata", mem_wdata, 32'h7878_7878);
    chk("R6 store wr", {31'h0, mem_wr}, 32'h1);
    set_req(1'b1, 2'b01, 32'h0000_5002, 32'h0, 12'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R6 half wdata", mem_wdata, 32'h5678_5678);
    set_req(1'b1, 2'b10, 32'h0000_5000, 32'h0, 12'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R6 word wdata", mem_wdata, 32'h1234_5678);
    set_req(1'b0, 2'b10, 32'h0000_5000, 32'h0, 12'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R6 load no wr", {31'h0, mem_wr}, 32'h0);
  endtask

  task automatic t_misalign();
    mem_rdata = 32'hFFFF_FFFF;
    set_req(1'b1, 2'b01, 32'h0000_6001, 32'h0, 12'h2, 1'b1, 1'b0, 1'b0, 1'b1);
    chk("R8 half err", {31'h0, align_err}, 32'h1);
    chk("R8 half lanes", {28'h0, mem_lane_en}, 32'h0);
    chk("R8 half wr", {31'h0, mem_wr}, 32'h0);
    chk("R8 half wb", {31'h0, base_wb_en}, 32'h0);
    set_req(1'b0, 2'b10, 32'h0000_6002, 32'h0, 12'h0, 1'b1, 1'b0, 1'b1, 1'b1);
    chk("R8 word err", {31'h0, align_err}, 32'h1);
    chk("R8 word load zero", load_data, 32'h0);
    chk("R8 word wb", {31'h0, base_wb_en}, 32'h0);
    set_req(1'b1, 2'b11, 32'h0000_6000, 32'h0, 12'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R8 rsvd err", {31'h0, align_err}, 32'h1);
    chk("R8 rsvd wr", {31'h0, mem_wr}, 32'h0);
  endtask

  task automatic t_mode_hold();
    @(negedge clk); cfg_big_endian = 1'b1;
    repeat (2) @(posedge clk);
    mem_rdata = 32'h1122_3344;
    set_req(1'b0, 2'b00, 32'h0000_7000, 32'h0, 12'h0, 1'b1, 1'b0, 1'b1, 1'b0);
    chk("R9 lanes after toggle", {28'h0, mem_lane_en}, 32'h1);
    chk("R9 load after toggle", load_data, 32'h0000_0044);
  endtask

  initial begin
    do_reset(1'b0);
    t_idle();
    t_pre_plain();
    t_pre_wb();
    t_post();
    t_sub();
    t_lanes_loads(1'b0);
    t_store();
    t_misalign();
    t_mode_hold();
    do_reset(1'b1);
    t_idle();
    t_lanes_loads(1'b1);
    @(negedge clk); req_valid = 1'b0;
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

endmodule